// File: doc/BRIEF.md
# Pause Flow-Control Resolver

This block settles which directions of pause-based flow control a MAC may use once a link has come up. It takes the duplex state, the two pause-capability bits the link partner advertised, and the locally configured preference. From these it works out one flow-control mode. That mode drives the receive-flow and transmit-flow enables of the MAC, and it sets the pause timer value that goes into outgoing pause frames.

The decision is taken only when the surrounding logic pulses a resolve strobe, for example on link-up or when autonegotiation completes. The result is registered and stays unchanged until the next strobe. This lets the partner-ability inputs and the preference change freely between link events.

Top module: `pause_resolve`

## Requirements
- R1: When the resolve strobe is sampled with the link at half duplex (`full_duplex_i` low), the resolved mode is none, whatever the partner bits and the preference are.
- R2: Modes are encoded on two bits as 0 none, 1 receive-only, 2 transmit-only, 3 both, and `local_pref_i` uses the same code. At full duplex, a partner advertising both pause and asymmetric pause yields a mode equal to the preference.
- R3: At full duplex, a partner advertising symmetric pause without asymmetric pause yields both when the preference is both, and none for every other preference.
- R4: At full duplex, a partner advertising neither pause bit yields none.
- R5: At full duplex, a partner advertising asymmetric pause without symmetric pause yields receive-only when the preference is both, and none for every other preference.
- R6: `rx_flow_en_o` is high exactly when the resolved mode is receive-only or both.
- R7: `tx_flow_en_o` is high exactly when the resolved mode is transmit-only or both.
- R8: `pause_time_o` is 0x40 whenever the resolved mode is not none, and 0 when it is none.
- R9: All outputs change on the clock edge that samples the strobe high and are visible one cycle after the strobe is applied. Input changes while the strobe is low have no effect on any output.
- R10: While `rst_ni` is low, the mode is none, both enables are low and the pause time is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| resolve_i | input | 1 | One-cycle strobe on link-up or autonegotiation complete |
| full_duplex_i | input | 1 | High when the link runs full duplex |
| partner_pause_i | input | 1 | Partner advertised symmetric pause |
| partner_asym_i | input | 1 | Partner advertised asymmetric pause |
| local_pref_i | input | 2 | Configured flow-control preference (mode code) |
| mode_o | output | 2 | Resolved flow-control mode |
| rx_flow_en_o | output | 1 | Honour received pause frames |
| tx_flow_en_o | output | 1 | Allow sending pause frames |
| pause_time_o | output | PAUSE_W | Pause timer value for transmitted pause frames |

## Verification
The hardest case to reach from the ports is proving that input changes between strobes are ignored. Because the outputs are a pure function of the inputs at the strobe, a design that leaks live inputs would still give the right answers during the table sweep. The bench therefore follows each strobe with several cycles in which duplex, partner bits and preference are changed to values that would resolve differently, with the strobe held low. It checks that every output keeps the value the last strobe set. The table itself is covered by sweeping all 32 combinations of duplex, partner bits and preference.

// File: rtl/pause_resolve_pkg.sv
package pause_resolve_pkg;

  localparam int unsigned MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    FC_NONE = 2'd0,
    FC_RX   = 2'd1,
    FC_TX   = 2'd2,
    FC_BOTH = 2'd3
  } fc_mode_e;

endpackage

// File: rtl/fc_table.sv
module fc_table
  import pause_resolve_pkg::*;
(
  input  logic     full_duplex_i,
  input  logic     partner_pause_i,
  input  logic     partner_asym_i,
  input  fc_mode_e pref_i,
  output fc_mode_e mode_o
);

  logic pref_both;
  assign pref_both = (pref_i == FC_BOTH);

  always_comb begin
    mode_o = FC_NONE;
    if (full_duplex_i) begin
      unique case ({partner_pause_i, partner_asym_i})
        2'b11:   mode_o = pref_i;
        2'b10:   mode_o = pref_both ? FC_BOTH : FC_NONE;
        2'b01:   mode_o = pref_both ? FC_RX : FC_NONE;
        default: mode_o = FC_NONE;
      endcase
    end
  end

endmodule

// File: rtl/fc_decode.sv
module fc_decode
  import pause_resolve_pkg::*;
#(
  parameter int unsigned          PAUSE_W   = 16,
  parameter logic [PAUSE_W-1:0]   PAUSE_VAL = 'h40
) (
  input  fc_mode_e           mode_i,
  output logic               rx_en_o,
  output logic               tx_en_o,
  output logic [PAUSE_W-1:0] pause_o
);

  assign rx_en_o = (mode_i == FC_RX) || (mode_i == FC_BOTH);
  assign tx_en_o = (mode_i == FC_TX) || (mode_i == FC_BOTH);
  assign pause_o = (mode_i == FC_NONE) ? '0 : PAUSE_VAL;

endmodule

// File: rtl/fc_hold.sv
module fc_hold
  import pause_resolve_pkg::*;
#(
  parameter int unsigned PAUSE_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  fc_mode_e           mode_d_i,
  input  logic               rx_d_i,
  input  logic               tx_d_i,
  input  logic [PAUSE_W-1:0] pause_d_i,
  output fc_mode_e           mode_q_o,
  output logic               rx_q_o,
  output logic               tx_q_o,
  output logic [PAUSE_W-1:0] pause_q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q_o  <= FC_NONE;
      rx_q_o    <= 1'b0;
      tx_q_o    <= 1'b0;
      pause_q_o <= '0;
    end else if (load_i) begin
      mode_q_o  <= mode_d_i;
      rx_q_o    <= rx_d_i;
      tx_q_o    <= tx_d_i;
      pause_q_o <= pause_d_i;
    end
  end

endmodule

// File: rtl/pause_resolve.sv
module pause_resolve
  import pause_resolve_pkg::*;
#(
  parameter int unsigned        PAUSE_W   = 16,
  parameter logic [PAUSE_W-1:0] PAUSE_VAL = 'h40
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               resolve_i,
  input  logic               full_duplex_i,
  input  logic               partner_pause_i,
  input  logic               partner_asym_i,
  input  logic [1:0]         local_pref_i,
  output logic [1:0]         mode_o,
  output logic               rx_flow_en_o,
  output logic               tx_flow_en_o,
  output logic [PAUSE_W-1:0] pause_time_o
);

  fc_mode_e           mode_d, mode_q;
  logic               rx_d, tx_d;
  logic [PAUSE_W-1:0] pause_d;

  fc_table u_table (
    .full_duplex_i  (full_duplex_i),
    .partner_pause_i(partner_pause_i),
    .partner_asym_i (partner_asym_i),
    .pref_i         (fc_mode_e'(local_pref_i)),
    .mode_o         (mode_d)
  );

  // decode ahead of the register so every output leaves a flop
  fc_decode #(.PAUSE_W(PAUSE_W), .PAUSE_VAL(PAUSE_VAL)) u_decode (
    .mode_i (mode_d),
    .rx_en_o(rx_d),
    .tx_en_o(tx_d),
    .pause_o(pause_d)
  );

  fc_hold #(.PAUSE_W(PAUSE_W)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (resolve_i),
    .mode_d_i (mode_d),
    .rx_d_i   (rx_d),
    .tx_d_i   (tx_d),
    .pause_d_i(pause_d),
    .mode_q_o (mode_q),
    .rx_q_o   (rx_flow_en_o),
    .tx_q_o   (tx_flow_en_o),
    .pause_q_o(pause_time_o)
  );

  assign mode_o = mode_q;

endmodule

// File: rtl/pause_resolve_chk.sv
module pause_resolve_chk #(
  parameter int unsigned PAUSE_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               resolve_i,
  input logic               full_duplex_i,
  input logic               partner_pause_i,
  input logic               partner_asym_i,
  input logic [1:0]         local_pref_i,
  input logic [1:0]         mode_o,
  input logic               rx_flow_en_o,
  input logic               tx_flow_en_o,
  input logic [PAUSE_W-1:0] pause_time_o
);

  a_r1_half_duplex_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resolve_i && !full_duplex_i) |=> (mode_o == 2'd0));

  a_r2_both_bits_follow_pref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resolve_i && full_duplex_i && partner_pause_i && partner_asym_i)
      |=> (mode_o == $past(local_pref_i)));

  a_r4_no_bits_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resolve_i && !partner_pause_i && !partner_asym_i) |=> (mode_o == 2'd0));

  a_r5_asym_only_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resolve_i && full_duplex_i && !partner_pause_i && partner_asym_i && local_pref_i == 2'd3)
      |=> (mode_o == 2'd1));

  a_r6_rx_flow_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_flow_en_o |-> (mode_o == 2'd1 || mode_o == 2'd3));

  a_r8_pause_zero_on_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0) |-> (pause_time_o == '0));

  a_r9_hold_between_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resolve_i |=> ($stable(mode_o) && $stable(rx_flow_en_o) &&
                    $stable(tx_flow_en_o) && $stable(pause_time_o)));

endmodule

bind pause_resolve pause_resolve_chk #(.PAUSE_W(PAUSE_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .resolve_i      (resolve_i),
  .full_duplex_i  (full_duplex_i),
  .partner_pause_i(partner_pause_i),
  .partner_asym_i (partner_asym_i),
  .local_pref_i   (local_pref_i),
  .mode_o         (mode_o),
  .rx_flow_en_o   (rx_flow_en_o),
  .tx_flow_en_o   (tx_flow_en_o),
  .pause_time_o   (pause_time_o)
);

// File: tb/pause_resolve_test.sv
module pause_resolve_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned PW = 16;

  typedef struct packed {
    logic [1:0]    mode;
    logic          rx;
    logic          tx;
    logic [PW-1:0] pause;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          resolve = 1'b0;
  logic          dup = 1'b0, pp = 1'b0, pa = 1'b0;
  logic [1:0]    pref = 2'd0;
  logic [1:0]    mode;
  logic          rx_en, tx_en;
  logic [PW-1:0] ptime;

  int total = 0;
  int bad = 0;
  exp_t q[$];
  exp_t last_exp;
  logic fired = 1'b0;

  always #2.5 clk = ~clk;

  pause_resolve uut (
    .clk_i(clk), .rst_ni(rst_n), .resolve_i(resolve),
    .full_duplex_i(dup), .partner_pause_i(pp), .partner_asym_i(pa),
    .local_pref_i(pref), .mode_o(mode), .rx_flow_en_o(rx_en),
    .tx_flow_en_o(tx_en), .pause_time_o(ptime)
  );

  function automatic exp_t model(logic d, logic p, logic a, logic [1:0] pr);
    exp_t e;
    logic [1:0] m;
    if (!d)            m = 2'd0;                       // R1
    else if (p && a)   m = pr;                         // R2
    else if (p)        m = (pr == 2'd3) ? 2'd3 : 2'd0; // R3
    else if (a)        m = (pr == 2'd3) ? 2'd1 : 2'd0; // R5
    else               m = 2'd0;                       // R4
    e.mode  = m;
    e.rx    = (m == 2'd1) || (m == 2'd3);              // R6
    e.tx    = (m == 2'd2) || (m == 2'd3);              // R7
    e.pause = (m != 2'd0) ? PW'(16'h40) : '0;          // R8
    return e;
  endfunction

  task automatic compare(string req, exp_t e);
    total++;
    if (mode !== e.mode || rx_en !== e.rx || tx_en !== e.tx || ptime !== e.pause) begin
      bad++;
      $display("FAIL %s: got mode=%0d rx=%b tx=%b pause=%h exp mode=%0d rx=%b tx=%b pause=%h",
               req, mode, rx_en, tx_en, ptime, e.mode, e.rx, e.tx, e.pause);
    end
  endtask

  function automatic string req_of(logic d, logic p, logic a);
    if (!d)          return "R1/R6/R7/R8";
    else if (p && a) return "R2/R6/R7/R8";
    else if (p)      return "R3/R6/R7/R8";
    else if (a)      return "R5/R6/R7/R8";
    else             return "R4/R6/R7/R8";
  endfunction

  string pend_req[$];

  // driver: one strobe, expected result queued
  task automatic drive(logic d, logic p, logic a, logic [1:0] pr);
    @(negedge clk);
    dup = d; pp = p; pa = a; pref = pr; resolve = 1'b1;
    q.push_back(model(d, p, a, pr));
    pend_req.push_back(req_of(d, p, a));
    @(negedge clk);
    resolve = 1'b0;
  endtask

  always @(posedge clk) fired <= resolve;

  // monitor: result is visible at the negedge after the sampling posedge (R9)
  always @(negedge clk) begin
    if (fired && q.size() > 0) begin
      exp_t e;
      string r;
      e = q.pop_front();
      r = pend_req.pop_front();
      last_exp = e;
      compare({r, "/R9"}, e);
    end
  end

  // R9: scramble inputs with strobe low, outputs must stay
  task automatic hold_check();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      dup = ~dup; pp = ~pp; pa = ~pa; pref = pref + 2'd1;
      @(negedge clk);
      compare("R9 hold", last_exp);
    end
  endtask

  initial begin
    exp_t zero;
    zero = '0;
    #1;
    compare("R10 reset", zero);
    dup = 1'b1; pp = 1'b1; pa = 1'b1; pref = 2'd3; resolve = 1'b1;
    repeat (3) @(negedge clk);
    compare("R10 reset with strobe", zero);
    resolve = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R10 after release", zero);

    for (int i = 0; i < 32; i++) begin
      drive(i[4], i[3], i[2], i[1:0]);
    end
    @(negedge clk);
    @(negedge clk);

    drive(1'b1, 1'b1, 1'b1, 2'd2);   // R2 transmit-only path
    @(negedge clk);
    hold_check();
    drive(1'b1, 1'b0, 1'b1, 2'd3);   // R5 receive-only
    @(negedge clk);
    hold_check();
    drive(1'b0, 1'b1, 1'b1, 2'd3);   // R1 back to none
    @(negedge clk);
    hold_check();
    drive(1'b1, 1'b1, 1'b0, 2'd3);   // R3 both
    drive(1'b1, 1'b1, 1'b0, 2'd1);   // R3 back-to-back strobes
    @(negedge clk);
    hold_check();

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule